// File: doc/BRIEF.md
# Input capture channel

This block is a single timer channel used as an input. It picks one of three candidate lines (the channel's own pin, the pin of the paired neighbouring channel, or an internal trigger), brings the chosen line into the clock domain, and rejects pulses that are shorter than a programmable number of samples. It then looks for the edge kind that the polarity bits select.

A prescaler divides the detected edges so that only every 1st, 2nd, 4th or 8th edge causes a capture. On a capture the free-running timebase value presented at `count_val` is stored in the capture register and a capture flag is raised. If a capture arrives while the flag is still set, an overcapture flag is raised as well. The interrupt line follows the capture flag when interrupts are enabled. Software clears both flags with a one-cycle clear pulse.

Top module: `capture_channel`

## Requirements
- R1: After reset, `cap_val` is zero and `cap_flag`, `over_flag` and `irq` are low.
- R2: `cfg_src` picks the observed line: 01 = `pin_own`, 10 = `pin_pair`, 11 = `trig_in`. With 00 no capture occurs. Lines that are not selected have no effect on any output.
- R3: Suppose an input change is present at clock edge k and holds. It is accepted at edge k+1+N, where N is the required stable sample count. A capture triggered by that acceptance stores the `count_val` sampled at that same edge.
- R4: `cfg_filt` codes 0..7 require 1, 2, 4, 6, 8, 12, 16 or 32 consecutive differing samples before a level change is accepted. A shorter pulse produces no edge.
- R5: `{cfg_pol_n, cfg_pol}` selects the edges: 00 = rising only, 01 = falling only, 11 = both edges. The value 10 behaves like 00.
- R6: `cfg_psc` codes 0..3 make a capture occur on every 1st, 2nd, 4th or 8th qualified edge. The edge count restarts from zero whenever the channel is disabled or has no source.
- R7: While `cfg_enable` is low, no capture occurs and `cap_val` and `cap_flag` keep their values.
- R8: A capture sets `cap_flag`. A `flag_clr` pulse clears it. When a capture and a clear coincide, the flag stays set.
- R9: `irq` is high exactly when `cap_flag` is high and `cfg_irq_en` is high.
- R10: A capture while `cap_flag` is already set, with no clear in the same cycle, sets `over_flag`. `flag_clr` clears `over_flag` as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_own | input | 1 | The channel's own input line |
| pin_pair | input | 1 | Input line of the paired neighbouring channel |
| trig_in | input | 1 | Internal trigger line |
| count_val | input | CNT_W | Timebase counter value |
| cfg_enable | input | 1 | Channel enable |
| cfg_src | input | 2 | Source select |
| cfg_filt | input | 3 | Filter code |
| cfg_pol_n | input | 1 | Upper edge-select bit |
| cfg_pol | input | 1 | Lower edge-select bit |
| cfg_psc | input | 2 | Edge prescaler code |
| cfg_irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the capture and overcapture flags |
| cap_val | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Capture flag |
| over_flag | output | 1 | Overcapture flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with the default 16-bit counter width. It drives `count_val` in steps of three, so every capture latches a value distinct from its neighbours, and an off-by-one-cycle capture shows up in `cap_val`. All eight filter codes, including the 32-sample case, are reachable at this width because the filter run counter does not depend on `CNT_W`. The reference model covers every source, polarity and prescaler combination that the bench visits, including a clear that lands in the same cycle as a capture.

// File: rtl/capture_channel.sv
module capture_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_own,
  input  logic             pin_pair,
  input  logic             trig_in,
  input  logic [CNT_W-1:0] count_val,
  input  logic             cfg_enable,
  input  logic [1:0]       cfg_src,
  input  logic [2:0]       cfg_filt,
  input  logic             cfg_pol_n,
  input  logic             cfg_pol,
  input  logic [1:0]       cfg_psc,
  input  logic             cfg_irq_en,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag,
  output logic             over_flag,
  output logic             irq
);
  localparam int MAX_RUN = 32;
  localparam int RUN_W   = $clog2(MAX_RUN + 1);
  localparam int PSC_W   = 3;

  logic [2:0] sync1, sync2;
  logic       lvl, sel;
  logic [RUN_W-1:0] run, need;
  logic [PSC_W-1:0] ev_cnt, psc_lim;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {trig_in, pin_pair, pin_own};
      sync2 <= sync1;
    end

  always_comb
    case (cfg_src)
      2'b01:   sel = sync2[0];
      2'b10:   sel = sync2[1];
      2'b11:   sel = sync2[2];
      default: sel = lvl;
    endcase

  always_comb
    case (cfg_filt)
      3'd0:    need = RUN_W'(1);
      3'd1:    need = RUN_W'(2);
      3'd2:    need = RUN_W'(4);
      3'd3:    need = RUN_W'(6);
      3'd4:    need = RUN_W'(8);
      3'd5:    need = RUN_W'(12);
      3'd6:    need = RUN_W'(16);
      default: need = RUN_W'(MAX_RUN);
    endcase

  wire diff   = sel != lvl;
  wire accept = diff && ((run + RUN_W'(1)) >= need);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl <= 1'b0;
      run <= '0;
    end else if (!diff) begin
      run <= '0;
    end else if (accept) begin
      lvl <= sel;
      run <= '0;
    end else begin
      run <= run + RUN_W'(1);
    end

  wire active   = cfg_enable && (cfg_src != 2'b00);
  wire rise     = accept && sel;
  wire fall     = accept && !sel;
  wire edge_hit = active && (cfg_pol ? (cfg_pol_n ? accept : fall) : rise);

  assign psc_lim = PSC_W'((4'd1 << cfg_psc) - 4'd1);
  wire cap_evt   = edge_hit && (ev_cnt >= psc_lim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ev_cnt <= '0;
    else if (!active)  ev_cnt <= '0;
    else if (cap_evt)  ev_cnt <= '0;
    else if (edge_hit) ev_cnt <= ev_cnt + PSC_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_val   <= '0;
      cap_flag  <= 1'b0;
      over_flag <= 1'b0;
    end else begin
      if (cap_evt) cap_val <= count_val;
      if (cap_evt)       cap_flag <= 1'b1;
      else if (flag_clr) cap_flag <= 1'b0;
      if (cap_evt && cap_flag && !flag_clr) over_flag <= 1'b1;
      else if (flag_clr)                     over_flag <= 1'b0;
    end

  assign irq = cap_flag && cfg_irq_en;
endmodule

// File: rtl/capture_channel_chk.sv
module capture_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic             flag_clr,
  input logic [CNT_W-1:0] count_val,
  input logic [CNT_W-1:0] cap_val,
  input logic             cap_flag,
  input logic             over_flag,
  input logic             irq,
  input logic             cap_evt
);
  AST_CAP_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_val == $past(count_val)); // R3
  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_enable) |-> $stable(cap_val)); // R7
  AST_CAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag); // R8
  AST_CLR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !cap_evt |=> !cap_flag && !over_flag); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cap_flag); // R9
  AST_OVERCAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt && cap_flag && !flag_clr |=> over_flag); // R10
endmodule

bind capture_channel capture_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .flag_clr(flag_clr),
  .count_val(count_val), .cap_val(cap_val), .cap_flag(cap_flag),
  .over_flag(over_flag), .irq(irq), .cap_evt(cap_evt)
);

// File: tb/sim_capture_channel.sv
module sim_capture_channel;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic pin_own = 0, pin_pair = 0, trig_in = 0;
  logic [CW-1:0] count_val = '0;
  logic cfg_enable = 1, cfg_pol_n = 0, cfg_pol = 0, cfg_irq_en = 1, flag_clr = 0;
  logic [1:0] cfg_src = 2'b01, cfg_psc = 2'b00;
  logic [2:0] cfg_filt = 3'd0;
  logic [CW-1:0] cap_val;
  logic cap_flag, over_flag, irq;

  capture_channel #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_own(pin_own), .pin_pair(pin_pair), .trig_in(trig_in),
    .count_val(count_val), .cfg_enable(cfg_enable), .cfg_src(cfg_src), .cfg_filt(cfg_filt),
    .cfg_pol_n(cfg_pol_n), .cfg_pol(cfg_pol), .cfg_psc(cfg_psc), .cfg_irq_en(cfg_irq_en),
    .flag_clr(flag_clr), .cap_val(cap_val), .cap_flag(cap_flag), .over_flag(over_flag), .irq(irq)
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;

  always @(negedge clk) count_val <= count_val + CW'(3);

  logic [2:0] hist[$] = '{3'b0, 3'b0, 3'b0};
  logic m_lvl = 0, m_flag = 0, m_over = 0;
  logic [CW-1:0] m_val = '0;
  int m_run = 0, m_ev = 0;

  function automatic int need_of(input logic [2:0] code);
    case (code)
      0: return 1;  1: return 2;  2: return 4;  3: return 6;
      4: return 8;  5: return 12; 6: return 16; default: return 32;
    endcase
  endfunction

  task automatic cmp(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycles, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [2:0] smp;
    logic sel, acc, hit, cap, act;
    cycles++;
    if (!rst_n) begin
      hist = '{3'b0, 3'b0, 3'b0};
      m_lvl = 0; m_run = 0; m_ev = 0; m_val = '0; m_flag = 0; m_over = 0;
    end else begin
      hist.push_front({trig_in, pin_pair, pin_own});
      smp = hist[2];
      void'(hist.pop_back());
      case (cfg_src)
        2'b01: sel = smp[0];
        2'b10: sel = smp[1];
        2'b11: sel = smp[2];
        default: sel = m_lvl;
      endcase
      acc = 0;
      if (sel != m_lvl) begin
        if (m_run + 1 >= need_of(cfg_filt)) begin acc = 1; m_lvl = sel; m_run = 0; end
        else m_run++;
      end else m_run = 0;
      act = cfg_enable && cfg_src != 0;
      if ({cfg_pol_n, cfg_pol} == 2'b11) hit = acc;
      else if ({cfg_pol_n, cfg_pol} == 2'b01) hit = acc && !m_lvl;
      else hit = acc && m_lvl;
      hit = hit && act;
      cap = 0;
      if (!act) m_ev = 0;
      else if (hit) begin
        if (m_ev + 1 >= (1 << cfg_psc)) begin cap = 1; m_ev = 0; end
        else m_ev++;
      end
      if (cap) m_val = count_val;
      if (cap && m_flag && !flag_clr) m_over = 1;
      else if (flag_clr) m_over = 0;
      if (cap) m_flag = 1;
      else if (flag_clr) m_flag = 0;
    end
    #1;
    if (!done) begin
      cmp(rst_n ? "R3 cap_val" : "R1 cap_val", cap_val, m_val);
      cmp(rst_n ? "R8 cap_flag" : "R1 cap_flag", cap_flag, m_flag);
      cmp(rst_n ? "R10 over_flag" : "R1 over_flag", over_flag, m_over);
      cmp(rst_n ? "R9 irq" : "R1 irq", irq, m_flag && cfg_irq_en);
      if (cycles > 50000) begin
        miscompares++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    flag_clr = 1; tick(1); flag_clr = 0; tick(1);
  endtask

  task automatic pulse_own(input int hi, input int lo);
    pin_own = 1; tick(hi); pin_own = 0; tick(lo);
  endtask

  initial begin
    logic [CW-1:0] held;
    tick(3);
    cmp("R1 reset cap_val", cap_val, 0);
    cmp("R1 reset flags", {cap_flag, over_flag, irq}, 0);
    rst_n = 1; tick(3);

    // R5 rising only
    pin_own = 1; tick(8);
    cmp("R5 rising captured", cap_flag, 1);
    clr(); pin_own = 0; tick(8);
    cmp("R5 falling ignored in rising mode", cap_flag, 0);
    // R5 falling only
    cfg_pol = 1; pin_own = 1; tick(8);
    cmp("R5 rising ignored in falling mode", cap_flag, 0);
    pin_own = 0; tick(8);
    cmp("R5 falling captured", cap_flag, 1);
    clr();
    // R5 both edges, R10 overcapture
    cfg_pol_n = 1; pin_own = 1; tick(8);
    cmp("R5 both: rising", cap_flag, 1);
    pin_own = 0; tick(8);
    cmp("R10 overcapture set", over_flag, 1);
    clr();
    cmp("R10 cleared", over_flag, 0);
    // R5 code 10 behaves as rising
    cfg_pol = 0; pin_own = 1; tick(8);
    cmp("R5 code 10 rising", cap_flag, 1);
    clr(); pin_own = 0; tick(8);
    cmp("R5 code 10 no falling", cap_flag, 0);
    cfg_pol_n = 0;

    // R2 sources
    cfg_src = 2'b10; tick(6); clr();
    pulse_own(6, 8);
    cmp("R2 own ignored when pair selected", cap_flag, 0);
    pin_pair = 1; tick(8);
    cmp("R2 pair captured", cap_flag, 1);
    pin_pair = 0; tick(8); clr();
    cfg_src = 2'b11; tick(6); clr();
    pin_pair = 1; tick(8); pin_pair = 0; tick(8);
    cmp("R2 pair ignored when trigger selected", cap_flag, 0);
    trig_in = 1; tick(8);
    cmp("R2 trigger captured", cap_flag, 1);
    trig_in = 0; tick(8); clr();
    cfg_src = 2'b00; tick(6); clr();
    pulse_own(6, 8); trig_in = 1; tick(8); trig_in = 0; tick(8);
    cmp("R2 no source no capture", cap_flag, 0);
    cfg_src = 2'b01; tick(6); clr();

    // R4 filter
    cfg_filt = 3'd3;
    pulse_own(4, 12);
    cmp("R4 short pulse rejected (6)", cap_flag, 0);
    pulse_own(10, 14);
    cmp("R4 long pulse accepted (6)", cap_flag, 1);
    clr(); cfg_filt = 3'd7;
    pulse_own(20, 40);
    cmp("R4 short pulse rejected (32)", cap_flag, 0);
    pulse_own(40, 45);
    cmp("R4 long pulse accepted (32)", cap_flag, 1);
    clr(); cfg_filt = 3'd0;
    for (int c = 1; c < 7; c++) begin
      cfg_filt = 3'(c); pulse_own(need_of(3'(c)) + 3, need_of(3'(c)) + 6);
    end
    cfg_filt = 3'd0; clr();

    // R6 prescaler
    cfg_psc = 2'd2;
    repeat (3) pulse_own(4, 6);
    cmp("R6 three edges no capture (div 4)", cap_flag, 0);
    pulse_own(4, 6);
    cmp("R6 fourth edge captures (div 4)", cap_flag, 1);
    clr(); cfg_psc = 2'd3;
    repeat (8) pulse_own(4, 6);
    cmp("R6 eighth edge captures (div 8)", cap_flag, 1);
    clr(); cfg_psc = 2'd1;
    pulse_own(4, 6);
    cfg_enable = 0; tick(2); cfg_enable = 1; tick(2);
    pulse_own(4, 6);
    cmp("R6 count restarts after disable", cap_flag, 0);
    pulse_own(4, 6);
    cmp("R6 second edge captures (div 2)", cap_flag, 1);
    clr(); cfg_psc = 2'd0;

    // R7 enable
    held = cap_val; cfg_enable = 0;
    pulse_own(6, 8);
    cmp("R7 disabled: no flag", cap_flag, 0);
    cmp("R7 disabled: value held", cap_val, held);
    cfg_enable = 1;

    // R9 irq gating
    pin_own = 1; tick(8); cfg_irq_en = 0; tick(1);
    cmp("R9 irq masked", irq, 0);
    cfg_irq_en = 1; tick(1);
    cmp("R9 irq raised", irq, 1);
    pin_own = 0; tick(6);

    // R8 clear coinciding with capture (flag already set)
    pin_own = 1; tick(2); flag_clr = 1; tick(1); flag_clr = 0; tick(3);
    cmp("R8 set wins over clear", cap_flag, 1);
    clr();
    cmp("R8 clear drops flag", cap_flag, 0);
    pin_own = 0; tick(10);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule